// File: doc/BRIEF.md
# SPI Status and Interrupt Controller

This block holds the error flags and the interrupt request of an SPI peripheral that works as master or slave with 16-bit characters and separate transmit and receive FIFOs. The datapath sends it single-cycle event strobes and levels. These cover data-register writes while the transmit FIFO is full, receive FIFO pushes while that FIFO is full, the slave-select level and the slave's bit count within the current character. They also cover shifter and transmit FIFO emptiness and baud generator timeouts. From these the block keeps four sticky error flags and one summary interrupt flag. It drives a single interrupt line gated by an enable.

Software reads the 5-bit status and clears flags by writing ones. An error flag only clears when the summary bit is written as 1 in the same write. When a slave transfer is aborted, the block also raises a level that tells the shifter to restart at the most significant bit when slave-select is next asserted.

Top module: `spi_irq_ctrl`

## Requirements
- R1: A data-register write strobe (`dat_wr`) while `tx_full` is 1 sets the transmit-overrun flag, status bit 1, on the next clock edge. This holds in master and slave mode alike.
- R2: A receive push (`rx_push`) while `rx_full` is 1 sets the receive-overrun flag, status bit 2, on the next edge. This holds in either mode.
- R3: While `spi_en` is 1, `master` is 1 and `ss_n` is 0, the collision flag, status bit 3, is set on the next edge.
- R4: When `master` is 0 and `ss_n` goes from 0 to 1 with `slv_bits` not 0, the abort flag, status bit 4, is set. A rise of `ss_n` with `slv_bits` equal to 0 sets nothing.
- R5: `restart_msb` becomes 1 on the same edge that records an abort. It stays 1 until the edge after `ss_n` next falls, and then it returns to 0.
- R6: A rise of the condition `shift_idle` AND `tx_empty` from 0 to 1 sets the summary interrupt flag, status bit 0. The rise is ignored when `dma_rx` or `dma_tx` is 1.
- R7: Every error event sets the summary flag together with its own error bit. The summary flag is 1 whenever any error bit is 1.
- R8: A `sw_start` strobe sets the summary flag on the next edge.
- R9: A `baud_to` strobe sets the summary flag only while `spi_en` is 0 and `birq_en` is 1. Otherwise it has no effect.
- R10: `irq` equals `irq_en` AND the summary flag.
- R11: A status write (`stat_wr`) clears an error bit only if `stat_wdata` has that bit and bit 0 both set to 1. The summary flag clears on a write with bit 0 set to 1, but only if no error bit is left set after the write.
- R12: When a set event and a clearing write reach the same flag in the same cycle, the flag stays 1.
- R13: After reset, `stat` is 0, `irq` is 0 and `restart_msb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_wr | input | 1 | CPU write strobe to the data register |
| tx_full | input | 1 | Transmit FIFO full |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_full | input | 1 | Receive FIFO full |
| shift_idle | input | 1 | Shift register has emptied |
| tx_empty | input | 1 | Transmit FIFO empty |
| ss_n | input | 1 | Slave-select level, active low |
| slv_bits | input | 4 | Bits already shifted in the current slave character |
| baud_to | input | 1 | Baud generator timeout strobe |
| irq_en | input | 1 | Interrupt output enable |
| master | input | 1 | 1 for master mode, 0 for slave mode |
| spi_en | input | 1 | SPI enable |
| dma_rx | input | 1 | Receive DMA enable |
| dma_tx | input | 1 | Transmit DMA enable |
| sw_start | input | 1 | Software start strobe |
| birq_en | input | 1 | Baud-timeout interrupt enable |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 5 | Write-one-to-clear mask |
| stat | output | 5 | Status: bit0 summary, bit1 tx overrun, bit2 rx overrun, bit3 collision, bit4 abort |
| irq | output | 1 | Interrupt request |
| restart_msb | output | 1 | Shifter must restart at bit 15 |

## Verification
The bench first runs directed phases. Each phase raises one event alone, so that the effect of each flag is seen apart from the others. Further phases fire that event together with the gate that should block it: DMA on for the data interrupt, SPI on for the baud timeout, zero bit count for the slave-select rise. Another phase puts a clearing write in the same cycle as a set, which shows whether set-over-clear holds and whether a pending error keeps the summary bit alive. A long pseudo-random phase then mixes all strobes, mode bits and partial clears. A behavioural model predicts every output on every clock, which exposes wrong priority or pairing between the error bits and the summary bit.

// File: rtl/spi_irq_pkg.sv
// Package: shared widths and status bit positions for the SPI status block.
// Assumes 16-bit characters; bit positions are what software decodes.
package spi_irq_pkg;
    parameter int CHAR_BITS = 16;
    parameter int CNT_W     = $clog2(CHAR_BITS);
    parameter int NUM_ERR   = 4;
    parameter int STAT_W    = NUM_ERR + 1;
    // status bit positions
    parameter int S_IRQ  = 0;
    parameter int S_TXOV = 1;
    parameter int S_RXOV = 2;
    parameter int S_COLL = 3;
    parameter int S_ABRT = 4;
endpackage

// File: rtl/spi_err_detect.sv
// Module: the four error detectors plus the abort restart indication.
// Assumes event strobes are one cycle wide and ss_n is already synchronised.
module spi_err_detect
    import spi_irq_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dat_wr,
    input  logic               tx_full,
    input  logic               rx_push,
    input  logic               rx_full,
    input  logic               ss_n,
    input  logic [CW-1:0]      slv_bits,
    input  logic               master,
    input  logic               spi_en,
    output logic [NUM_ERR-1:0] err_evt,
    output logic               restart_msb
);
    logic ss_q;
    logic ss_rise;
    logic ss_fall;
    logic abort;

    // Purpose: remember the previous slave-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ss_q <= 1'b1;
        else        ss_q <= ss_n;
    end

    assign ss_rise = ss_n & ~ss_q;
    assign ss_fall = ~ss_n & ss_q;
    assign abort   = ~master & ss_rise & (slv_bits != '0);

    // Purpose: build the per-error event vector, ordered like status bits 1..4.
    always_comb begin
        err_evt                 = '0;
        err_evt[S_TXOV-1]       = dat_wr & tx_full;
        err_evt[S_RXOV-1]       = rx_push & rx_full;
        err_evt[S_COLL-1]       = spi_en & master & ~ss_n;
        err_evt[S_ABRT-1]       = abort;
    end

    // Purpose: hold the restart request from an abort until the next select.
    always_ff @(posedge clk) begin
        if (!rst_n)       restart_msb <= 1'b0;
        else if (abort)   restart_msb <= 1'b1;
        else if (ss_fall) restart_msb <= 1'b0;
    end
endmodule

// File: rtl/spi_irq_src.sv
// Module: non-error interrupt sources (data done, software start, baud timeout).
// Assumes the done condition is a level; only its rising edge counts.
module spi_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_idle,
    input  logic tx_empty,
    input  logic dma_rx,
    input  logic dma_tx,
    input  logic sw_start,
    input  logic baud_to,
    input  logic spi_en,
    input  logic birq_en,
    output logic src_evt
);
    logic done;
    logic done_q;
    logic data_evt;
    logic baud_evt;

    assign done = shift_idle & tx_empty;

    // Purpose: delay the done level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done;
    end

    assign data_evt = done & ~done_q & ~(dma_rx | dma_tx);
    assign baud_evt = baud_to & ~spi_en & birq_en;
    assign src_evt  = data_evt | sw_start | baud_evt;
endmodule

// File: rtl/spi_stat_regs.sv
// Module: sticky status flags with write-one-to-clear and set priority.
// Assumes an error bit may only clear when the summary bit is written too.
module spi_stat_regs
    import spi_irq_pkg::*;
#(
    parameter int NE = NUM_ERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] err_evt,
    input  logic          src_evt,
    input  logic          wr,
    input  logic [NE:0]   wdata,
    output logic [NE:0]   stat_q
);
    logic          clr_ok;
    logic [NE-1:0] err_d;
    logic          sum_d;

    assign clr_ok = wr & wdata[S_IRQ];

    for (genvar g = 0; g < NE; g++) begin : g_err
        // Purpose: next value of one error bit, set beating clear.
        always_comb begin
            if (err_evt[g])                  err_d[g] = 1'b1;
            else if (clr_ok && wdata[g + 1]) err_d[g] = 1'b0;
            else                             err_d[g] = stat_q[g + 1];
        end
    end

    // Purpose: summary bit follows any event and survives while errors remain.
    always_comb begin
        if ((|err_evt) || src_evt || (|err_d)) sum_d = 1'b1;
        else if (clr_ok)                       sum_d = 1'b0;
        else                                   sum_d = stat_q[S_IRQ];
    end

    // Purpose: register the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= {err_d, sum_d};
    end
endmodule

// File: rtl/spi_irq_ctrl.sv
// Module: top of the SPI status and interrupt controller.
// Assumes all inputs are synchronous to clk; irq is a combinational gate of
// the registered summary flag.
module spi_irq_ctrl
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_wr,
    input  logic              tx_full,
    input  logic              rx_push,
    input  logic              rx_full,
    input  logic              shift_idle,
    input  logic              tx_empty,
    input  logic              ss_n,
    input  logic [CNT_W-1:0]  slv_bits,
    input  logic              baud_to,
    input  logic              irq_en,
    input  logic              master,
    input  logic              spi_en,
    input  logic              dma_rx,
    input  logic              dma_tx,
    input  logic              sw_start,
    input  logic              birq_en,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat,
    output logic              irq,
    output logic              restart_msb
);
    logic [NUM_ERR-1:0] err_evt;
    logic               src_evt;

    spi_err_detect #(.CW(CNT_W)) u_det (
        .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .tx_full(tx_full),
        .rx_push(rx_push), .rx_full(rx_full), .ss_n(ss_n),
        .slv_bits(slv_bits), .master(master), .spi_en(spi_en),
        .err_evt(err_evt), .restart_msb(restart_msb)
    );

    spi_irq_src u_src (
        .clk(clk), .rst_n(rst_n), .shift_idle(shift_idle), .tx_empty(tx_empty),
        .dma_rx(dma_rx), .dma_tx(dma_tx), .sw_start(sw_start),
        .baud_to(baud_to), .spi_en(spi_en), .birq_en(birq_en),
        .src_evt(src_evt)
    );

    spi_stat_regs #(.NE(NUM_ERR)) u_stat (
        .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .src_evt(src_evt),
        .wr(stat_wr), .wdata(stat_wdata), .stat_q(stat)
    );

    assign irq = irq_en & stat[S_IRQ];
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
// Module: property checker for spi_irq_ctrl, attached with bind below.
// Assumes the same synchronous active-low reset as the design.
module spi_irq_ctrl_chk
    import spi_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dat_wr,
    input logic              tx_full,
    input logic              rx_push,
    input logic              rx_full,
    input logic              ss_n,
    input logic              master,
    input logic              spi_en,
    input logic              sw_start,
    input logic              baud_to,
    input logic              birq_en,
    input logic [STAT_W-1:0] stat,
    input logic              restart_msb
);
    AST_TXOV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr && tx_full |=> stat[S_TXOV]); // R1
    AST_RXOV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |=> stat[S_RXOV]); // R2
    AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en && master && !ss_n |=> stat[S_COLL]); // R3
    AST_RESTART_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_msb) |-> stat[S_ABRT]); // R5
    AST_ERR_KEEPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[STAT_W-1:1] != '0) |-> stat[S_IRQ]); // R7
    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start |=> stat[S_IRQ]); // R8
    AST_BAUD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        baud_to && !spi_en && birq_en |=> stat[S_IRQ]); // R9
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .tx_full(tx_full),
    .rx_push(rx_push), .rx_full(rx_full), .ss_n(ss_n), .master(master),
    .spi_en(spi_en), .sw_start(sw_start), .baud_to(baud_to),
    .birq_en(birq_en), .stat(stat), .restart_msb(restart_msb)
);

// File: tb/spi_irq_ctrl_bench.sv
`timescale 1ns/100ps
// Bench: behavioural model of the status flags, compared on every clock.
module spi_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dat_wr = 0, tx_full = 0, rx_push = 0, rx_full = 0;
    logic       shift_idle = 0, tx_empty = 0, ss_n = 1, baud_to = 0;
    logic [3:0] slv_bits = 0;
    logic       irq_en = 0, master = 0, spi_en = 0, dma_rx = 0, dma_tx = 0;
    logic       sw_start = 0, birq_en = 0, stat_wr = 0;
    logic [4:0] stat_wdata = 0;
    logic [4:0] stat;
    logic       irq, restart_msb;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    bit m_sum, m_tx, m_rx, m_col, m_abt, m_rst, p_ss, p_done;

    always #2.5 clk = ~clk;

    spi_irq_ctrl u_spi_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .tx_full(tx_full),
        .rx_push(rx_push), .rx_full(rx_full), .shift_idle(shift_idle),
        .tx_empty(tx_empty), .ss_n(ss_n), .slv_bits(slv_bits),
        .baud_to(baud_to), .irq_en(irq_en), .master(master), .spi_en(spi_en),
        .dma_rx(dma_rx), .dma_tx(dma_tx), .sw_start(sw_start),
        .birq_en(birq_en), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat(stat), .irq(irq), .restart_msb(restart_msb)
    );

    // reference model: next state from the inputs seen at this edge
    always @(posedge clk) begin
        bit e_tx, e_rx, e_col, e_abt, e_other, clr, any_err;
        if (!rst_n) begin
            {m_sum, m_tx, m_rx, m_col, m_abt, m_rst} = '0;
            p_ss = 1; p_done = 0;
        end else begin
            e_tx  = dat_wr && tx_full;
            e_rx  = rx_push && rx_full;
            e_col = spi_en && master && !ss_n;
            e_abt = !master && ss_n && !p_ss && (slv_bits != 0);
            e_other = (shift_idle && tx_empty && !p_done && !dma_rx && !dma_tx)
                      || sw_start || (baud_to && !spi_en && birq_en);
            clr = stat_wr && stat_wdata[0];
            if (e_tx) m_tx = 1; else if (clr && stat_wdata[1]) m_tx = 0;
            if (e_rx) m_rx = 1; else if (clr && stat_wdata[2]) m_rx = 0;
            if (e_col) m_col = 1; else if (clr && stat_wdata[3]) m_col = 0;
            if (e_abt) m_abt = 1; else if (clr && stat_wdata[4]) m_abt = 0;
            any_err = m_tx || m_rx || m_col || m_abt;
            if (e_tx || e_rx || e_col || e_abt || e_other || any_err) m_sum = 1;
            else if (clr) m_sum = 0;
            if (e_abt) m_rst = 1; else if (!ss_n && p_ss) m_rst = 0;
            p_ss = ss_n;
            p_done = shift_idle && tx_empty;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk("R6/R7/R8/R9/R11/R12 summary bit0", stat[0], m_sum);
            chk("R1 tx overrun bit1", stat[1], m_tx);
            chk("R2 rx overrun bit2", stat[2], m_rx);
            chk("R3 collision bit3", stat[3], m_col);
            chk("R4 abort bit4", stat[4], m_abt);
            chk("R5 restart_msb", restart_msb, m_rst);
            chk("R10 irq", irq, irq_en && m_sum);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            dat_wr = 0; rx_push = 0; baud_to = 0; sw_start = 0; stat_wr = 0;
        end
    endtask

    task automatic wclr(input logic [4:0] m);
        stat_wr = 1; stat_wdata = m; tick();
    endtask

    task automatic expect_stat(input string tag, input logic [4:0] e);
        @(negedge clk);
        checks++;
        if (stat !== e) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, stat, e);
        end
        @(posedge clk); #1;
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        tick(3);
        expect_stat("R13 reset status", 5'b0);
        rst_n = 1; tick(2);
        expect_stat("R13 idle after reset", 5'b0);
        irq_en = 1;
        // R1
        tx_full = 1; dat_wr = 1; tick(); tx_full = 0;
        expect_stat("R1 tx overrun", 5'b00011);
        wclr(5'b00010); // error bit without summary bit: no clear (R11)
        expect_stat("R11 error kept without bit0", 5'b00011);
        wclr(5'b00011); tick();
        expect_stat("R11 cleared pair", 5'b0);
        // R2 with set-wins (R12)
        rx_full = 1; rx_push = 1; tick();
        rx_push = 1; stat_wr = 1; stat_wdata = 5'b00101; tick(); rx_full = 0;
        expect_stat("R12 set beats clear", 5'b00101);
        wclr(5'b00001); // summary alone cannot clear while error pending
        expect_stat("R11 summary held by error", 5'b00101);
        wclr(5'b00101);
        // R3
        spi_en = 1; master = 1; ss_n = 0; tick(); ss_n = 1; tick();
        expect_stat("R3 collision", 5'b01001);
        wclr(5'b01001);
        // R4/R5 slave abort
        master = 0; ss_n = 0; slv_bits = 5; tick(2);
        ss_n = 1; tick();
        expect_stat("R4 abort", 5'b10001);
        tick(2); ss_n = 0; slv_bits = 0; tick(3);
        ss_n = 1; tick(); // clean rise, no abort
        wclr(5'b10001); tick();
        expect_stat("R4 clean rise no abort", 5'b0);
        // R6 data edge, then DMA gating
        shift_idle = 1; tx_empty = 1; tick();
        expect_stat("R6 data interrupt", 5'b00001);
        wclr(5'b00001); shift_idle = 0; tick();
        dma_tx = 1; shift_idle = 1; tick(2);
        expect_stat("R6 suppressed by DMA", 5'b0);
        dma_tx = 0; shift_idle = 0; tx_empty = 0;
        // R8
        sw_start = 1; tick();
        expect_stat("R8 start", 5'b00001);
        wclr(5'b00001);
        // R9
        birq_en = 1; baud_to = 1; tick();
        expect_stat("R9 baud ignored while enabled", 5'b0);
        spi_en = 0; baud_to = 1; tick();
        expect_stat("R9 baud timeout", 5'b00001);
        irq_en = 0; tick(2); irq_en = 1;
        wclr(5'b00001);
        // mixed random phase
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom;
            dat_wr = r[0]; tx_full = r[1]; rx_push = r[2] & r[3]; rx_full = r[4];
            shift_idle = r[5]; tx_empty = r[6]; ss_n = r[7] | r[8];
            slv_bits = r[12:9]; baud_to = r[13]; irq_en = r[14];
            master = r[15]; spi_en = r[16] & r[17]; dma_rx = r[18] & r[19];
            dma_tx = r[20] & r[21]; sw_start = r[22] & r[23] & r[24];
            birq_en = r[25]; stat_wr = r[26]; stat_wdata = r[31:27];
            @(posedge clk); #1;
        end
        summary();
    end
endmodule